// File: doc/BRIEF.md
# Programmable DRAM Command Sequencer

This block replays a short stored program of DRAM command words onto a command/address bus. Software fills a 32-entry program store through a simple write port. Each entry has two words: a command word that holds the bus value, and a control word that says how long the entry lasts, how often its command repeats, which entry follows it, and whether the entry ends the program. Software then picks one target port and pulses start. The engine walks the entries from entry 0 and holds the bus for as long as the program runs. At the end it releases the port so normal traffic can take over.

Between commands, during delays and while idle, the engine drives a deselect word: every chip select is high, the clock-enable bit keeps the value of the last command issued, and all other bits are zero. The terminating entry issues no command of its own. Its job is to make sure the wait of the entry before it is fully served before the engine reports completion. Completion, failure and activity appear in a 5-bit status word, and a separate flag is high only when that word shows a clean finish.

Top module: `cmd_seq_engine`

## Requirements
- R1: A write with `wr_sel_i`=0 stores `wr_data_i` as the command word of entry `wr_idx_i`, and a write with `wr_sel_i`=1 stores its low 19 bits as that entry's control word. The other word of the entry is left unchanged.
- R2: A start pulse while idle sets busy (`stat_o[4]`) on the next cycle, clears done and the failure code, and begins execution at entry 0. A start pulse while busy has no effect on the running program.
- R3: An entry with delay D (control bits 13:6) and repeat R (control bits 17:14) occupies max(D,1)×(R+1) cycles. Its command word is driven on the first cycle of each of the R+1 blocks of max(D,1) cycles, and the deselect word is driven on the other cycles.
- R4: After a non-end entry, execution continues at the entry named by its next-index field (control bits 5:0), so entries can run in any order.
- R5: An entry whose next index equals its own index repeats forever and keeps busy high until a stop is requested.
- R6: An entry with the end bit (control bit 18) set drives the deselect word for one cycle and does not drive its own command word. Busy then clears and done (`stat_o[3]`) sets, and done stays set until the next start.
- R7: A next index of 32 or more, reached at the end of an entry's occupancy, stops the engine. Busy clears, done stays clear, and the failure code `stat_o[2:0]` becomes 3'b001.
- R8: A stop pulse while busy lets the current entry finish its occupancy. The engine then halts with busy and done clear and no failure code. A stop pulse while idle has no effect.
- R9: The deselect word has bits 1:0 (chip selects, active low) at 1, bit 2 (clock enable) equal to bit 2 of the last command word driven (0 after reset), and all other bits at 0. It is driven whenever the engine is idle.
- R10: `stat_o` is {busy, done, fail[2:0]}. Busy and done are never set together, and `ok_o` is high only when `stat_o` equals 5'b01000.
- R11: `port_sel_i` is captured at start. While busy, `port_own_o` is the one-hot decode of the captured value, and later changes of `port_sel_i` have no effect. While idle, `port_own_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Program store write strobe |
| wr_sel_i | input | 1 | 0 selects the command word, 1 selects the control word |
| wr_idx_i | input | 5 | Entry written |
| wr_data_i | input | 64 | Write data |
| port_sel_i | input | 2 | Port to own for the next run |
| start_i | input | 1 | Start pulse, used only when idle |
| stop_i | input | 1 | Halt request, served at the next entry boundary |
| bus_o | output | 64 | Command/address bus value |
| port_own_o | output | 4 | One-hot port ownership while busy |
| stat_o | output | 5 | {busy, done, fail[2:0]} |
| ok_o | output | 1 | Clean-finish flag |

## Verification
The bench keeps its own copy of the program store and works out the expected bus value for every busy cycle. It then runs several programs against that trace. A straight-line program with repeated blocks checks cycle counting and confirms that the end entry only pads time. A program that jumps between entries, with a zero delay and a change of clock enable, checks next-index following and clock-enable carry-over. A program with an out-of-range next index checks the failure path. A partial rewrite of one control word shows that the two words of an entry are stored separately. A self-looping entry and a stop raised in the middle of an entry show that halting waits for the entry boundary and never reports done. Stray start and stop pulses, and a port-select change in the middle of a run, must leave the trace unchanged.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;

  localparam logic [2:0] FAIL_NONE     = 3'b000;
  localparam logic [2:0] FAIL_BAD_NEXT = 3'b001;

  // Cycles spent on one entry: a zero delay still takes one cycle per block.
  function automatic int unsigned entry_span(int unsigned dly, int unsigned rep);
    return ((dly == 0) ? 1 : dly) * (rep + 1);
  endfunction

endpackage

// File: rtl/cmd_seq_store.sv
module cmd_seq_store #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5,
  parameter int CMD_W = 64,
  parameter int CTL_W = 19
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CMD_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CMD_W-1:0] rd_cmd,
  output logic [CTL_W-1:0] rd_ctl
);

  logic [CMD_W-1:0] cmd_mem [DEPTH];
  logic [CTL_W-1:0] ctl_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < DEPTH)) begin
      if (wr_sel) ctl_mem[wr_idx] <= wr_data[CTL_W-1:0];
      else        cmd_mem[wr_idx] <= wr_data;
    end
  end

  assign rd_cmd = cmd_mem[rd_idx];
  assign rd_ctl = ctl_mem[rd_idx];

endmodule

// File: rtl/cmd_seq_timer.sv
module cmd_seq_timer
  import cmd_seq_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int REP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [DLY_W-1:0] dly,
  input  logic [REP_W-1:0] rep,
  output logic             first_slot_o,
  output logic             last_o
);

  logic [DLY_W-1:0] blk_cnt;
  logic [REP_W-1:0] rep_cnt;
  logic [DLY_W-1:0] blk_last;
  logic [31:0]      occ_cnt;

  assign blk_last     = (dly == '0) ? '0 : dly - DLY_W'(1);
  assign first_slot_o = (blk_cnt == '0);
  assign last_o       = (blk_cnt == blk_last) && (rep_cnt == rep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_cnt <= '0;
      rep_cnt <= '0;
    end else if (load) begin
      blk_cnt <= '0;
      rep_cnt <= '0;
    end else if (adv) begin
      if (blk_cnt == blk_last) begin
        blk_cnt <= '0;
        rep_cnt <= (rep_cnt == rep) ? '0 : rep_cnt + REP_W'(1);
      end else begin
        blk_cnt <= blk_cnt + DLY_W'(1);
      end
    end
  end

  // Occupancy counter kept only to cross-check the block/repeat counters.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   occ_cnt <= '0;
    else if (load)                occ_cnt <= '0;
    else if (adv && last_o)       occ_cnt <= '0;
    else if (adv)                 occ_cnt <= occ_cnt + 32'd1;
  end

  a_r3_entry_span: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last_o) |-> (occ_cnt + 32'd1 == entry_span(32'(dly), 32'(rep))));

  a_r3_blk_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (blk_cnt <= blk_last));

endmodule

// File: rtl/cmd_seq_engine.sv
module cmd_seq_engine
  import cmd_seq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int CMD_W  = 64,
  parameter int CS_W   = 2,
  parameter int DLY_W  = 8,
  parameter int REP_W  = 4,
  parameter int NPORTS = 4,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int PSEL_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int NXT_W   = IDX_W + 1,
  localparam int DLY_LSB = NXT_W,
  localparam int REP_LSB = DLY_LSB + DLY_W,
  localparam int END_BIT = REP_LSB + REP_W,
  localparam int CTL_W   = END_BIT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CMD_W-1:0]  wr_data_i,
  input  logic [PSEL_W-1:0] port_sel_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic [CMD_W-1:0]  bus_o,
  output logic [NPORTS-1:0] port_own_o,
  output logic [4:0]        stat_o,
  output logic              ok_o
);

  seq_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic              done_q;
  logic [2:0]        fail_q;
  logic              stop_pend;
  logic [PSEL_W-1:0] port_q;
  logic              cke_q;

  logic [CMD_W-1:0]  rd_cmd;
  logic [CTL_W-1:0]  rd_ctl;
  logic [NXT_W-1:0]  nxt;
  logic [DLY_W-1:0]  dly;
  logic [REP_W-1:0]  rep;
  logic              end_bit;
  logic              first_slot;
  logic              last_slot;

  // Named internal events
  logic running, start_go, at_end, boundary, cmd_slot, halt_req, next_bad;
  logic [CMD_W-1:0] desel_w;

  cmd_seq_store #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CMD_W(CMD_W), .CTL_W(CTL_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_en_i),
    .wr_sel  (wr_sel_i),
    .wr_idx  (wr_idx_i),
    .wr_data (wr_data_i),
    .rd_idx  (idx),
    .rd_cmd  (rd_cmd),
    .rd_ctl  (rd_ctl)
  );

  assign nxt     = rd_ctl[NXT_W-1:0];
  assign dly     = rd_ctl[DLY_LSB +: DLY_W];
  assign rep     = rd_ctl[REP_LSB +: REP_W];
  assign end_bit = rd_ctl[END_BIT];

  assign running  = (state == ST_RUN);
  assign start_go = start_i && !running;
  assign at_end   = running && end_bit;
  assign cmd_slot = running && !end_bit && first_slot;
  assign boundary = running && !end_bit && last_slot;
  assign halt_req = stop_i || stop_pend;
  assign next_bad = (nxt >= NXT_W'(DEPTH));

  cmd_seq_timer #(
    .DLY_W(DLY_W), .REP_W(REP_W)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (start_go),
    .adv          (running && !end_bit),
    .dly          (dly),
    .rep          (rep),
    .first_slot_o (first_slot),
    .last_o       (last_slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      done_q    <= 1'b0;
      fail_q    <= FAIL_NONE;
      stop_pend <= 1'b0;
      port_q    <= '0;
    end else if (start_go) begin
      state     <= ST_RUN;
      idx       <= '0;
      done_q    <= 1'b0;
      fail_q    <= FAIL_NONE;
      stop_pend <= 1'b0;
      port_q    <= port_sel_i;
    end else if (running) begin
      if (stop_i) stop_pend <= 1'b1;
      if (at_end) begin
        state     <= ST_IDLE;
        done_q    <= !halt_req;
        stop_pend <= 1'b0;
      end else if (boundary) begin
        if (halt_req) begin
          state     <= ST_IDLE;
          stop_pend <= 1'b0;
        end else if (next_bad) begin
          state  <= ST_IDLE;
          fail_q <= FAIL_BAD_NEXT;
        end else begin
          idx <= nxt[IDX_W-1:0];
        end
      end
    end
  end

  // Clock enable follows the last command actually placed on the bus.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cke_q <= 1'b0;
    else if (cmd_slot) cke_q <= rd_cmd[CS_W];
  end

  always_comb begin
    desel_w            = '0;
    desel_w[CS_W-1:0]  = '1;
    desel_w[CS_W]      = cke_q;
  end

  assign bus_o  = cmd_slot ? rd_cmd : desel_w;
  assign stat_o = {running, done_q, fail_q};
  assign ok_o   = (stat_o == 5'b01000);

  for (genvar p = 0; p < NPORTS; p++) begin : g_own
    assign port_own_o[p] = running && (port_q == PSEL_W'(p));
  end

  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[4]) |-> $past(start_i));

  a_r4_follow_next: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !halt_req && !next_bad) |=> (running && idx == $past(nxt[IDX_W-1:0])));

  a_r6_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[3]) |-> $past(at_end));

  a_r7_fail_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[2:0] != 3'b000) |-> (!stat_o[4] && !stat_o[3]));

  a_r8_stop_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && (at_end || boundary)) |=> (!stat_o[4] && !stat_o[3]));

  a_r9_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_o[4] |-> (bus_o[CS_W-1:0] == {CS_W{1'b1}}));

  a_r9_cke_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_slot |-> (bus_o[CS_W] == $past(bus_o[CS_W])));

  a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_o[4] && stat_o[3]));

  a_r11_own_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[4] |-> $onehot(port_own_o));

  a_r11_own_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_o[4] |-> (port_own_o == '0));

endmodule

// File: tb/cmd_seq_engine_tb.sv
module cmd_seq_engine_tb_top;

  localparam int MAXT = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [4:0]  wr_idx_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [1:0]  port_sel_i = '0;
  logic        start_i = 1'b0;
  logic        stop_i = 1'b0;
  logic [63:0] bus_o;
  logic [3:0]  port_own_o;
  logic [4:0]  stat_o;
  logic        ok_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [63:0] m_cmd [32];
  logic [63:0] m_ctl [32];
  logic        m_cke = 1'b0;
  logic [63:0] exp_bus [MAXT];

  always #5 clk = ~clk;

  cmd_seq_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .port_sel_i(port_sel_i),
    .start_i(start_i), .stop_i(stop_i), .bus_o(bus_o),
    .port_own_o(port_own_o), .stat_o(stat_o), .ok_o(ok_o)
  );

  function automatic logic [63:0] desel(logic k);
    return {61'b0, k, 2'b11};
  endfunction

  function automatic logic [63:0] mk_cmd(logic [1:0] cs, logic k, logic [15:0] pay);
    return {40'b0, pay, 5'b0, k, cs};
  endfunction

  function automatic logic [63:0] mk_ctl(int nx, int d, int r, logic e);
    logic [63:0] v;
    v = '0;
    v[5:0]   = 6'(nx);
    v[13:6]  = 8'(d);
    v[17:14] = 4'(r);
    v[18]    = e;
    return v;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_word(int idx, logic sel, logic [63:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_idx_i = 5'(idx); wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (sel) m_ctl[idx] = {45'b0, data[18:0]};
    else     m_cmd[idx] = data;
  endtask

  task automatic wr_entry(int idx, logic [63:0] cmd, logic [63:0] ctl);
    wr_word(idx, 1'b0, cmd);
    wr_word(idx, 1'b1, ctl);
  endtask

  // Expected bus trace from the bench's own copy of the program.
  task automatic build_trace(output int n, output logic [4:0] fst, output logic cke_out);
    int i;
    logic k;
    i = 0; n = 0; fst = 5'b0; k = m_cke;
    while (n < MAXT) begin
      logic [63:0] c;
      int d, r, blk, nx;
      c = m_ctl[i];
      if (c[18]) begin
        exp_bus[n] = desel(k); n++;
        fst = 5'b01000;
        break;
      end
      d = int'(c[13:6]); r = int'(c[17:14]); nx = int'(c[5:0]);
      blk = (d == 0) ? 1 : d;
      for (int rr = 0; rr <= r; rr++) begin
        for (int b = 0; b < blk; b++) begin
          if (n < MAXT) begin
            if (b == 0) begin exp_bus[n] = m_cmd[i]; k = m_cmd[i][2]; end
            else exp_bus[n] = desel(k);
            n++;
          end
        end
      end
      if (nx >= 32) begin fst = 5'b00001; break; end
      i = nx;
    end
    cke_out = k;
  endtask

  task automatic run_prog(string req, int port, int extra_start, int stop_at,
                          int len_ovr, int stat_ovr);
    int n, cyc, mism, own_bad;
    logic [4:0] fst;
    logic kend;
    logic [63:0] first_act, first_exp;
    build_trace(n, fst, kend);
    if (len_ovr >= 0) n = len_ovr;
    if (stat_ovr >= 0) fst = 5'(stat_ovr);
    @(negedge clk);
    port_sel_i = 2'(port); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    port_sel_i = 2'(port ^ 1);   // R11: later select changes must not matter
    cyc = 0; mism = 0; own_bad = 0; first_act = '0; first_exp = '0;
    while (stat_o[4] && cyc < MAXT) begin
      if (cyc < n && bus_o !== exp_bus[cyc]) begin
        if (mism == 0) begin first_act = bus_o; first_exp = exp_bus[cyc]; end
        mism++;
      end
      if (port_own_o !== 4'(1 << port)) own_bad++;
      start_i = (cyc == extra_start);
      stop_i  = (cyc == stop_at);
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0; stop_i = 1'b0;
    chk(req, "R3 busy cycles", 64'(cyc), 64'(n));
    chk(req, "R3 bus trace first mismatch", first_act, first_exp);
    chk(req, "R11 port ownership while busy", 64'(own_bad), 64'd0);
    chk(req, "R10 final status", 64'(stat_o), 64'(fst));
    chk(req, "R10 ok flag", 64'(ok_o), 64'(fst == 5'b01000));
    chk(req, "R11 no ownership when idle", 64'(port_own_o), 64'd0);
    if (stop_at < 0) m_cke = kend;
    chk(req, "R9 idle deselect word", bus_o, desel(m_cke));
  endtask

  task automatic t_reset();
    chk("R10", "reset status", 64'(stat_o), 64'd0);
    chk("R10", "reset ok", 64'(ok_o), 64'd0);
    chk("R11", "reset ownership", 64'(port_own_o), 64'd0);
    chk("R9", "reset bus deselect cke low", bus_o, desel(1'b0));
  endtask

  task automatic t_straight();
    wr_entry(0, mk_cmd(2'b10, 1'b1, 16'hA0A0), mk_ctl(1, 3, 1, 1'b0));
    wr_entry(1, mk_cmd(2'b01, 1'b1, 16'hB1B1), mk_ctl(2, 1, 0, 1'b0));
    wr_entry(2, mk_cmd(2'b00, 1'b0, 16'hEEEE), mk_ctl(2, 0, 0, 1'b1));
    // R2: a start pulse in cycle 4 of the run is ignored
    run_prog("R6", 2, 4, -1, -1, -1);
    repeat (6) @(negedge clk);
    chk("R6", "done held after wait", 64'(stat_o), 64'h08);
    chk("R9", "cke carried into idle", bus_o, desel(1'b1));
  endtask

  task automatic t_branch();
    wr_entry(0, mk_cmd(2'b10, 1'b1, 16'h1111), mk_ctl(5, 0, 2, 1'b0));
    wr_entry(5, mk_cmd(2'b01, 1'b1, 16'h5555), mk_ctl(2, 2, 0, 1'b0));
    wr_entry(2, mk_cmd(2'b10, 1'b0, 16'h2222), mk_ctl(7, 3, 1, 1'b0));
    wr_entry(7, mk_cmd(2'b00, 1'b1, 16'h7777), mk_ctl(7, 0, 0, 1'b1));
    run_prog("R4", 0, -1, -1, -1, -1);
    chk("R9", "cke low carried after branch run", bus_o, desel(1'b0));
  endtask

  task automatic t_bad_next();
    wr_entry(0, mk_cmd(2'b10, 1'b1, 16'hC0C0), mk_ctl(1, 2, 0, 1'b0));
    wr_entry(1, mk_cmd(2'b01, 1'b1, 16'hC1C1), mk_ctl(40, 1, 1, 1'b0));
    run_prog("R7", 3, -1, -1, -1, -1);
    chk("R7", "failure code", 64'(stat_o[2:0]), 64'd1);
  endtask

  task automatic t_partial_write();
    // R1: only the control word of entry 1 changes; its command word stays
    wr_word(1, 1'b1, mk_ctl(2, 1, 0, 1'b0));
    wr_entry(2, mk_cmd(2'b00, 1'b0, 16'hD2D2), mk_ctl(3, 0, 0, 1'b1));
    run_prog("R1", 1, -1, -1, -1, -1);
    chk("R2", "start cleared failure code", 64'(stat_o[2:0]), 64'd0);
  endtask

  task automatic t_stop_idle();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    chk("R8", "stop while idle keeps status", 64'(stat_o), 64'h08);
    run_prog("R8", 1, -1, -1, -1, -1);
  endtask

  task automatic t_stop_mid();
    wr_entry(0, mk_cmd(2'b10, 1'b1, 16'hF0F0), mk_ctl(1, 10, 0, 1'b0));
    wr_entry(1, mk_cmd(2'b11, 1'b0, 16'hF1F1), mk_ctl(1, 0, 0, 1'b1));
    // R8: stop in cycle 3 of a 10-cycle entry: 10 busy cycles, no done
    m_cke = 1'b1;
    run_prog("R8", 0, -1, 3, 10, 0);
  endtask

  task automatic t_park();
    int cmds;
    wr_entry(0, mk_cmd(2'b01, 1'b1, 16'h9A9A), mk_ctl(0, 2, 0, 1'b0));
    @(negedge clk); port_sel_i = 2'd1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    cmds = 0;
    for (int c = 0; c < 40; c++) begin
      if (bus_o[1:0] != 2'b11) cmds++;
      @(negedge clk);
    end
    chk("R5", "still busy while parked", 64'(stat_o[4]), 64'd1);
    chk("R5", "commands issued while parked", 64'(cmds), 64'd20);
    stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    chk("R8", "busy until entry boundary", 64'(stat_o[4]), 64'd1);
    @(negedge clk);
    chk("R8", "halted without done", 64'(stat_o), 64'd0);
    chk("R10", "ok low after stop", 64'(ok_o), 64'd0);
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_straight();
    t_branch();
    t_bad_next();
    t_partial_write();
    t_stop_idle();
    t_stop_mid();
    t_park();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule